// File: doc/BRIEF.md
# Flash Controller Command Sequencer

This block sits between a register bus and a non-volatile memory array. It holds the timing, address and control registers for the array. A single write to the control register starts one array operation: mass erase, page erase, program, reference-cell erase or trim-code recall. While that operation runs, the block keeps a busy flag raised and drives one abstract strobe toward the array. The strobe lasts a programmed number of clock cycles. A hold phase of programmed length follows it, and then the operation retires.

Every register write is blocked while the write-protect bit in the control register is set. A write that is blocked this way raises a sticky error flag, and software clears that flag by writing one to it in the status register. Phase lengths come from cycle-count fields packed into three timing registers. The lengths are captured together with the selected page when the operation starts. Reads are combinational from the register offset.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the control register reads 0x0000_0002, meaning protection is on and no operation is pending. Status, timing and address read 0, busy is low and no strobe is active.
- R2: The registers sit at these byte offsets: control 0x00, timing0 0x04, timing1 0x08, timing2 0x0c, address 0x20, status 0x2c.
  - Timing0 keeps wait states in bits 5:0 and the hold count in bits 31:16.
  - Timing1 keeps the erase count in bits 23:0.
  - Timing2 keeps the program count in bits 15:0, cycles-per-100ns in bits 23:16 and cycles-per-10ns in bits 27:24.
  - Address keeps bits 23:0.
  - Bits outside these fields read 0.
- R3: While control bit1 (protect) is set, a write to a timing or address register changes nothing and sets status bit1. A control write that carries any operation bit (bits 7:3) starts nothing and also sets status bit1. Control bits 0, 1 and 8 are still updated by that write.
- R4: Writing status with bit1 set clears the error flag. Writing status with bit1 clear leaves the flag unchanged.
- R5: An accepted operation raises the busy output and status bit0 in the cycle after the control write.
- R6: The main phase drives exactly one bit of the strobe vector. The bits are: 0 mass erase (control bit3), 1 page erase (bit4), 2 program (bit5), 3 reference-cell erase (bit6), 4 recall (bit7). The phase lasts for a number of cycles taken from one field, and a count of 0 counts as 1:
  - the three erases use timing1[23:0];
  - program uses timing2[15:0];
  - recall uses timing2[23:16].
- R7: After the main phase, the hold output is high for timing0[31:16] cycles (0 counts as 1) with no strobe active, and then busy drops. Busy therefore lasts main length plus hold length.
- R8: The accepted operation bit reads back as set in the control register while busy is high, and it clears in the same cycle that busy falls.
- R9: A control write while busy is high is ignored entirely, including its protect, sleep and auto-program bits.
- R10: When a control write sets several operation bits, only the lowest-numbered one runs.
- R11: The page output takes address bits 23:12 at the start of an operation and holds them until the next start.
- R12: Status bits 2, 3 and 4 mirror the redundancy-off, discharged and brown-out inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Byte offset for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| stat_redun_off | input | 1 | Redundancy-disabled status input |
| stat_discharged | input | 1 | Discharged status input |
| stat_brownout | input | 1 | Brown-out status input |
| arr_strobe | output | 5 | One-hot main-phase strobe per operation |
| arr_hold | output | 1 | Hold phase active |
| arr_page | output | 12 | Page index latched at operation start |
| busy | output | 1 | Operation in progress |

## Verification
A register write takes effect at the clock edge that samples it, so both the read-back value and busy are due one cycle after the write cycle. The strobe is due over the next N cycles, the hold over the H cycles after those, and busy falls together with the operation bit on the last hold edge. The bench keeps a behavioural model that counts down the remaining main and hold cycles. It compares every output against the model at each falling edge, before it drives the next stimulus. It also counts the busy cycles of each operation against N+H, with 0 counted as 1.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    localparam int REG_AW = 6;
    localparam int NUM_OPS = 5;

    localparam logic [REG_AW-1:0] OFS_CTRL = 6'h00;
    localparam logic [REG_AW-1:0] OFS_TIM0 = 6'h04;
    localparam logic [REG_AW-1:0] OFS_TIM1 = 6'h08;
    localparam logic [REG_AW-1:0] OFS_TIM2 = 6'h0C;
    localparam logic [REG_AW-1:0] OFS_ADDR = 6'h20;
    localparam logic [REG_AW-1:0] OFS_STAT = 6'h2C;

    // control field positions
    localparam int CB_SLEEP = 0;
    localparam int CB_PROT  = 1;
    localparam int CB_OP_LO = 3;
    localparam int CB_AUTO  = 8;

    // strobe / operation index, priority order (lowest wins)
    localparam int OP_MASS   = 0;
    localparam int OP_PAGE   = 1;
    localparam int OP_PROG   = 2;
    localparam int OP_REFC   = 3;
    localparam int OP_RECALL = 4;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_MAIN = 2'd1,
        PH_HOLD = 2'd2
    } phase_e;

endpackage

// File: rtl/flash_seq_prio.sv
module flash_seq_prio #(
    parameter int N = 5
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_pick
            if (i == 0) begin : g_first
                assign grant[i] = req[i];
            end else begin : g_rest
                assign grant[i] = req[i] & ~(|req[i-1:0]);
            end
        end
    endgenerate
endmodule

// File: rtl/flash_seq_regs.sv
module flash_seq_regs
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int PAGE_SHIFT = 12,
    parameter int WAIT_W     = 6,
    parameter int NVH_W      = 16,
    parameter int ERASE_W    = 24,
    parameter int PROG_W     = 16,
    parameter int H100_W     = 8,
    parameter int T10_W      = 4,
    parameter int CNT_W      = 24,
    localparam int PAGE_W    = ADDR_W - PAGE_SHIFT
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [REG_AW-1:0]   addr,
    input  logic [31:0]         wdata,
    output logic [31:0]         rdata,
    input  logic                busy,
    input  logic                done,
    input  logic                st_redun,
    input  logic                st_disch,
    input  logic                st_brown,
    output logic                start,
    output logic [CNT_W-1:0]    main_len,
    output logic [NVH_W-1:0]    hold_len,
    output logic [PAGE_W-1:0]   page_sel,
    output logic [NUM_OPS-1:0]  ops
);

    typedef struct packed {
        logic                sleep;
        logic                prot;
        logic [NUM_OPS-1:0]  ops;
        logic                autop;
        logic [WAIT_W-1:0]   waits;
        logic [NVH_W-1:0]    nvh;
        logic [ERASE_W-1:0]  erase;
        logic [PROG_W-1:0]   prog;
        logic [H100_W-1:0]   h100;
        logic [T10_W-1:0]    t10;
        logic [ADDR_W-1:0]   faddr;
        logic                wer;
    } regs_t;

    regs_t st_d, st_q;

    logic [NUM_OPS-1:0] op_req;
    logic [NUM_OPS-1:0] op_grant;
    logic               unused_wdata;

    assign op_req       = wdata[CB_OP_LO +: NUM_OPS];
    assign unused_wdata = ^wdata;

    flash_seq_prio #(.N(NUM_OPS)) prio_i (
        .req   (op_req),
        .grant (op_grant)
    );

    // next-state computation
    always_comb begin
        st_d  = st_q;
        start = 1'b0;

        if (done) begin
            st_d.ops = '0;
        end

        if (wr_en) begin
            case (addr)
                OFS_CTRL: begin
                    if (!busy) begin
                        st_d.sleep = wdata[CB_SLEEP];
                        st_d.prot  = wdata[CB_PROT];
                        st_d.autop = wdata[CB_AUTO];
                        if (|op_req) begin
                            if (st_q.prot) begin
                                st_d.wer = 1'b1;
                            end else begin
                                st_d.ops = op_grant;
                                start    = 1'b1;
                            end
                        end
                    end
                end
                OFS_TIM0: begin
                    if (st_q.prot) begin
                        st_d.wer = 1'b1;
                    end else begin
                        st_d.waits = wdata[WAIT_W-1:0];
                        st_d.nvh   = wdata[16 +: NVH_W];
                    end
                end
                OFS_TIM1: begin
                    if (st_q.prot) begin
                        st_d.wer = 1'b1;
                    end else begin
                        st_d.erase = wdata[ERASE_W-1:0];
                    end
                end
                OFS_TIM2: begin
                    if (st_q.prot) begin
                        st_d.wer = 1'b1;
                    end else begin
                        st_d.prog = wdata[PROG_W-1:0];
                        st_d.h100 = wdata[16 +: H100_W];
                        st_d.t10  = wdata[24 +: T10_W];
                    end
                end
                OFS_ADDR: begin
                    if (st_q.prot) begin
                        st_d.wer = 1'b1;
                    end else begin
                        st_d.faddr = wdata[ADDR_W-1:0];
                    end
                end
                OFS_STAT: begin
                    if (wdata[1]) begin
                        st_d.wer = 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    // phase length for the granted operation
    always_comb begin
        main_len = '0;
        if (op_grant[OP_MASS] | op_grant[OP_PAGE] | op_grant[OP_REFC]) begin
            main_len = CNT_W'(st_q.erase);
        end else if (op_grant[OP_PROG]) begin
            main_len = CNT_W'(st_q.prog);
        end else if (op_grant[OP_RECALL]) begin
            main_len = CNT_W'(st_q.h100);
        end
    end

    assign hold_len = st_q.nvh;
    assign page_sel = st_q.faddr[ADDR_W-1:PAGE_SHIFT];
    assign ops      = st_q.ops;

    // read mux
    always_comb begin
        rdata = '0;
        case (addr)
            OFS_CTRL: begin
                rdata[CB_SLEEP]               = st_q.sleep;
                rdata[CB_PROT]                = st_q.prot;
                rdata[CB_OP_LO +: NUM_OPS]    = st_q.ops;
                rdata[CB_AUTO]                = st_q.autop;
            end
            OFS_TIM0: begin
                rdata[WAIT_W-1:0]  = st_q.waits;
                rdata[16 +: NVH_W] = st_q.nvh;
            end
            OFS_TIM1: rdata[ERASE_W-1:0] = st_q.erase;
            OFS_TIM2: begin
                rdata[PROG_W-1:0]   = st_q.prog;
                rdata[16 +: H100_W] = st_q.h100;
                rdata[24 +: T10_W]  = st_q.t10;
            end
            OFS_ADDR: rdata[ADDR_W-1:0] = st_q.faddr;
            OFS_STAT: begin
                rdata[0] = busy;
                rdata[1] = st_q.wer;
                rdata[2] = st_redun;
                rdata[3] = st_disch;
                rdata[4] = st_brown;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.prot <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/flash_seq_timer.sv
module flash_seq_timer
    import flash_seq_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int HOLD_W = 16,
    parameter int PAGE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  main_len,
    input  logic [HOLD_W-1:0] hold_len,
    input  logic [PAGE_W-1:0] page_in,
    output logic              busy,
    output logic              main_act,
    output logic              hold_act,
    output logic              done,
    output logic [PAGE_W-1:0] page_out
);

    typedef struct packed {
        phase_e              ph;
        logic [CNT_W-1:0]    cnt;
        logic [HOLD_W-1:0]   hold;
        logic [PAGE_W-1:0]   page;
    } tmr_t;

    tmr_t tm_d, tm_q;

    always_comb begin
        tm_d = tm_q;
        done = 1'b0;
        case (tm_q.ph)
            PH_IDLE: begin
                if (start) begin
                    tm_d.ph   = PH_MAIN;
                    tm_d.cnt  = (main_len == '0) ? CNT_W'(1) : main_len;
                    tm_d.hold = hold_len;
                    tm_d.page = page_in;
                end
            end
            PH_MAIN: begin
                if (tm_q.cnt <= CNT_W'(1)) begin
                    tm_d.ph  = PH_HOLD;
                    tm_d.cnt = (tm_q.hold == '0) ? CNT_W'(1) : CNT_W'(tm_q.hold);
                end else begin
                    tm_d.cnt = tm_q.cnt - CNT_W'(1);
                end
            end
            PH_HOLD: begin
                if (tm_q.cnt <= CNT_W'(1)) begin
                    tm_d.ph  = PH_IDLE;
                    tm_d.cnt = '0;
                    done     = 1'b1;
                end else begin
                    tm_d.cnt = tm_q.cnt - CNT_W'(1);
                end
            end
            default: tm_d.ph = PH_IDLE;
        endcase
    end

    assign busy     = (tm_q.ph != PH_IDLE);
    assign main_act = (tm_q.ph == PH_MAIN);
    assign hold_act = (tm_q.ph == PH_HOLD);
    assign page_out = tm_q.page;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tm_q    <= '0;
            tm_q.ph <= PH_IDLE;
        end else begin
            tm_q <= tm_d;
        end
    end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int PAGE_SHIFT = 12,
    parameter int WAIT_W     = 6,
    parameter int NVH_W      = 16,
    parameter int ERASE_W    = 24,
    parameter int PROG_W     = 16,
    parameter int H100_W     = 8,
    parameter int T10_W      = 4,
    localparam int PAGE_W    = ADDR_W - PAGE_SHIFT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [5:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic               stat_redun_off,
    input  logic               stat_discharged,
    input  logic               stat_brownout,
    output logic [4:0]         arr_strobe,
    output logic               arr_hold,
    output logic [PAGE_W-1:0]  arr_page,
    output logic               busy
);

    localparam int CNT_W = (ERASE_W > PROG_W) ? ERASE_W : PROG_W;

    logic               start;
    logic               done;
    logic               main_act;
    logic [CNT_W-1:0]   main_len;
    logic [NVH_W-1:0]   hold_len;
    logic [PAGE_W-1:0]  page_sel;
    logic [NUM_OPS-1:0] ops;

    flash_seq_regs #(
        .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .WAIT_W(WAIT_W),
        .NVH_W(NVH_W), .ERASE_W(ERASE_W), .PROG_W(PROG_W),
        .H100_W(H100_W), .T10_W(T10_W), .CNT_W(CNT_W)
    ) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .busy     (busy),
        .done     (done),
        .st_redun (stat_redun_off),
        .st_disch (stat_discharged),
        .st_brown (stat_brownout),
        .start    (start),
        .main_len (main_len),
        .hold_len (hold_len),
        .page_sel (page_sel),
        .ops      (ops)
    );

    flash_seq_timer #(
        .CNT_W(CNT_W), .HOLD_W(NVH_W), .PAGE_W(PAGE_W)
    ) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .main_len (main_len),
        .hold_len (hold_len),
        .page_in  (page_sel),
        .busy     (busy),
        .main_act (main_act),
        .hold_act (arr_hold),
        .done     (done),
        .page_out (arr_page)
    );

    assign arr_strobe = ops & {NUM_OPS{main_act}};

endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk
    import flash_seq_pkg::*;
#(
    parameter int PAGE_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [5:0]        reg_addr,
    input logic [31:0]       reg_rdata,
    input logic              busy,
    input logic [4:0]        arr_strobe,
    input logic              arr_hold,
    input logic [PAGE_W-1:0] arr_page
);

    AST_BUSY_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(reg_wr && (reg_addr == OFS_CTRL))); // R5

    AST_STATUS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFS_STAT) |-> (reg_rdata[0] == busy)); // R5

    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(arr_strobe)); // R10

    AST_STROBE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_strobe != 5'd0) |-> busy); // R6

    AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        arr_hold |-> (busy && (arr_strobe == 5'd0))); // R7

    AST_FALL_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(arr_hold)); // R7

    AST_PAGE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(arr_page)); // R11

endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.PAGE_W(PAGE_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_rdata  (reg_rdata),
    .busy       (busy),
    .arr_strobe (arr_strobe),
    .arr_hold   (arr_hold),
    .arr_page   (arr_page)
);

// File: tb/flash_cmd_seq_tb_top.sv
module flash_cmd_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_addr = 6'h00;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        s_redun = 1'b0;
    logic        s_disch = 1'b0;
    logic        s_brown = 1'b0;
    logic [4:0]  arr_strobe;
    logic        arr_hold;
    logic [11:0] arr_page;
    logic        busy;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    flash_cmd_seq dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .stat_redun_off(s_redun), .stat_discharged(s_disch), .stat_brownout(s_brown),
        .arr_strobe(arr_strobe), .arr_hold(arr_hold), .arr_page(arr_page), .busy(busy)
    );

    // behavioural model state
    bit          m_sleep, m_prot, m_auto, m_wer;
    logic [4:0]  m_ops;
    logic [5:0]  m_waits;
    logic [15:0] m_nvh;
    logic [23:0] m_erase;
    logic [15:0] m_prog;
    logic [7:0]  m_h100;
    logic [3:0]  m_t10;
    logic [23:0] m_addr;
    logic [11:0] m_page;
    int          m_main, m_hold;
    bit          mb_busy, mb_prot;
    int          m_len, m_pick;

    task automatic m_reset();
        m_sleep = 0; m_prot = 1; m_auto = 0; m_wer = 0; m_ops = '0;
        m_waits = '0; m_nvh = '0; m_erase = '0; m_prog = '0; m_h100 = '0;
        m_t10 = '0; m_addr = '0; m_page = '0; m_main = 0; m_hold = 0;
    endtask

    initial m_reset();

    always @(posedge clk) begin
        if (!rst_n) begin
            m_reset();
        end else begin
            mb_busy = (m_main > 0) || (m_hold > 0);
            if (m_main > 0) begin
                m_main = m_main - 1;
            end else if (m_hold > 0) begin
                m_hold = m_hold - 1;
                if (m_hold == 0) m_ops = '0;
            end
            if (reg_wr) begin
                case (reg_addr)
                    6'h00: if (!mb_busy) begin
                        mb_prot = m_prot;
                        m_sleep = reg_wdata[0];
                        m_prot  = reg_wdata[1];
                        m_auto  = reg_wdata[8];
                        if (reg_wdata[7:3] != 5'd0) begin
                            if (mb_prot) begin
                                m_wer = 1;
                            end else begin
                                m_pick = -1;
                                for (int k = 4; k >= 0; k--)
                                    if (reg_wdata[3+k]) m_pick = k;
                                m_ops = 5'(1 << m_pick);
                                if (m_pick == 2) m_len = int'(m_prog);
                                else if (m_pick == 4) m_len = int'(m_h100);
                                else m_len = int'(m_erase);
                                m_main = (m_len == 0) ? 1 : m_len;
                                m_hold = (m_nvh == 0) ? 1 : int'(m_nvh);
                                m_page = m_addr[23:12];
                            end
                        end
                    end
                    6'h04: if (m_prot) m_wer = 1;
                           else begin m_waits = reg_wdata[5:0]; m_nvh = reg_wdata[31:16]; end
                    6'h08: if (m_prot) m_wer = 1; else m_erase = reg_wdata[23:0];
                    6'h0C: if (m_prot) m_wer = 1;
                           else begin m_prog = reg_wdata[15:0]; m_h100 = reg_wdata[23:16];
                                      m_t10 = reg_wdata[27:24]; end
                    6'h20: if (m_prot) m_wer = 1; else m_addr = reg_wdata[23:0];
                    6'h2C: if (reg_wdata[1]) m_wer = 0;
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [31:0] exp_rd(logic [5:0] a);
        logic [31:0] r = '0;
        case (a)
            6'h00: r = {23'd0, m_auto, m_ops, 1'b0, m_prot, m_sleep};
            6'h04: r = {m_nvh, 10'd0, m_waits};
            6'h08: r = {8'd0, m_erase};
            6'h0C: r = {4'd0, m_t10, m_h100, m_prog};
            6'h20: r = {8'd0, m_addr};
            6'h2C: r = {27'd0, s_brown, s_disch, s_redun, m_wer,
                        ((m_main > 0) || (m_hold > 0))};
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic chk(logic [31:0] act, logic [31:0] exp, string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", req, act, exp, $time);
        end
    endtask

    // compare at the falling edge, then drive the next inputs
    task automatic cycle(bit wr, logic [5:0] a, logic [31:0] d);
        @(negedge clk);
        chk(32'(busy), 32'((m_main > 0) || (m_hold > 0)), "R5");
        chk(32'(arr_strobe), 32'((m_main > 0) ? m_ops : 5'd0), "R6");
        chk(32'(arr_hold), 32'((m_main == 0) && (m_hold > 0)), "R7");
        chk(32'(arr_page), 32'(m_page), "R11");
        chk(reg_rdata, exp_rd(reg_addr), cur_req);
        reg_wr = wr; reg_addr = a; reg_wdata = d;
    endtask

    task automatic expect_rd(logic [5:0] a, logic [31:0] e, string req);
        cycle(0, a, 32'h0);
        #1;
        chk(reg_rdata, e, req);
    endtask

    task automatic run_op(logic [31:0] ctrl, int exp_cycles, string req);
        int n = 0;
        cycle(1, 6'h00, ctrl);
        for (int i = 0; i < 300; i++) begin
            cycle(0, 6'h00, 32'h0);
            if (busy) n++;
            else break;
        end
        chk(32'(n), 32'(exp_cycles), req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) cycle(0, 6'h00, 32'h0);
        rst_n = 1'b1;
        // R1 reset state
        cur_req = "R1";
        expect_rd(6'h00, 32'h0000_0002, "R1");
        expect_rd(6'h2C, 32'h0, "R1");
        expect_rd(6'h08, 32'h0, "R1");

        // R3 protection blocks writes
        cur_req = "R3";
        cycle(1, 6'h08, 32'h0000_0055);
        expect_rd(6'h08, 32'h0, "R3");
        expect_rd(6'h2C, 32'h0000_0002, "R3");
        cycle(1, 6'h00, 32'h0000_0122);
        expect_rd(6'h00, 32'h0000_0102, "R3");
        chk(32'(busy), 32'h0, "R3");

        // R4 write-one-to-clear
        cur_req = "R4";
        cycle(1, 6'h2C, 32'h0000_0001);
        expect_rd(6'h2C, 32'h0000_0002, "R4");
        cycle(1, 6'h2C, 32'h0000_0002);
        expect_rd(6'h2C, 32'h0, "R4");

        // R2 field layout
        cur_req = "R2";
        cycle(1, 6'h00, 32'h0);
        cycle(1, 6'h04, 32'hFFFF_FFFF);
        expect_rd(6'h04, 32'hFFFF_003F, "R2");
        cycle(1, 6'h08, 32'hFFFF_FFFF);
        expect_rd(6'h08, 32'h00FF_FFFF, "R2");
        cycle(1, 6'h0C, 32'hFFFF_FFFF);
        expect_rd(6'h0C, 32'h0FFF_FFFF, "R2");
        cycle(1, 6'h20, 32'hFFFF_FFFF);
        expect_rd(6'h20, 32'h00FF_FFFF, "R2");
        expect_rd(6'h14, 32'h0, "R2");

        cycle(1, 6'h04, 32'h0003_0005);
        cycle(1, 6'h08, 32'h0000_0006);
        cycle(1, 6'h0C, 32'h0102_0004);
        cycle(1, 6'h20, 32'h0000_0000);

        // R5 R6 R7 R8 each operation
        cur_req = "R8";
        run_op(32'h08, 9, "R7 mass erase");
        run_op(32'h20, 7, "R7 program");
        run_op(32'h80, 5, "R6 recall");
        run_op(32'h40, 9, "R6 refcell");
        expect_rd(6'h00, 32'h0, "R8");

        // R11 page latch
        cur_req = "R11";
        cycle(1, 6'h20, 32'h0000_5ABC);
        cycle(1, 6'h00, 32'h10);
        cycle(1, 6'h20, 32'h0000_9000);
        #1;
        chk(32'(arr_page), 32'h5, "R11");
        for (int i = 0; i < 12; i++) cycle(0, 6'h2C, 32'h0);

        // R9 writes while busy ignored
        cur_req = "R9";
        cycle(1, 6'h00, 32'h08);
        cycle(1, 6'h00, 32'h20);
        cycle(1, 6'h00, 32'h0102);
        expect_rd(6'h00, 32'h08, "R9");
        for (int i = 0; i < 12; i++) cycle(0, 6'h00, 32'h0);
        expect_rd(6'h00, 32'h0, "R9");

        // R10 priority
        cur_req = "R10";
        cycle(1, 6'h00, 32'hF0);
        expect_rd(6'h00, 32'h10, "R10");
        #1;
        chk(32'(arr_strobe), 32'h02, "R10");
        for (int i = 0; i < 12; i++) cycle(0, 6'h00, 32'h0);

        // R6 zero counts treated as one
        cur_req = "R6";
        cycle(1, 6'h04, 32'h0);
        cycle(1, 6'h08, 32'h0);
        run_op(32'h08, 2, "R6 zero length");

        // R12 status inputs
        cur_req = "R12";
        s_redun = 1'b1; s_brown = 1'b1;
        expect_rd(6'h2C, 32'h0000_0014, "R12");
        s_redun = 1'b0; s_disch = 1'b1; s_brown = 1'b0;
        expect_rd(6'h2C, 32'h0000_0008, "R12");

        cur_req = "R3";
        cycle(1, 6'h00, 32'h02);
        expect_rd(6'h00, 32'h02, "R3");
        cycle(0, 6'h00, 32'h0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule